// File: doc/BRIEF.md
# Idle-Mode Power Controller

This block decides when an 8-bit microcontroller core is halted to save power and when it resumes. Software sets an idle request bit in a small power-control register; from the next oscillator clock the core's clock enable drops while the timer, serial and I/O clock enable keeps running. The core's whole state is frozen because its registers simply stop being enabled. Clocks are never gated here, only enables are driven.

Idle ends in one of two ways. An interrupt request that is individually enabled, with the global interrupt enable set, clears the idle bit and re-enables the core clock so the service routine can run. An external reset or a watchdog reset clears the idle bit and starts an internal reset pulse of exactly two machine cycles (24 oscillator clocks). Because the oscillator has kept running, that pulse starts at once. Only after a power-on, when the oscillator has just started, is a parameterised startup wait placed in front of the reset pulse.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: A register write with bit 0 set, while running and out of reset, sets the idle bit from the next clock; a write with bit 0 clear leaves the core running. Read data bit 0 always shows the current idle bit.
- R2: While the idle bit is set, the core clock enable is low and the peripheral clock enable is high.
- R3: While idle, a request on any line whose individual enable is set, with the global enable set, clears the idle bit and raises the core clock enable on the next clock.
- R4: While idle, requests whose individual enable is clear, or any request while the global enable is clear, leave the block idle.
- R5: An external reset request, from idle or from normal running, clears the idle bit and raises the internal reset on the next clock with no startup wait; the internal reset stays high for exactly 24 clocks after the last clock the request was seen.
- R6: A watchdog reset request has the same effect as an external reset, including when the block is idle.
- R7: After the power-on input releases, the internal reset is high and both clock enables are low for STARTUP_CLKS clocks, then the internal reset stays high for 24 more clocks with both clock enables high.
- R8: When a reset request and a qualified interrupt arrive on the same clock during idle, the reset wins: the internal reset starts and the idle bit is cleared.
- R9: Reset requests during the power-on startup wait are ignored and do not lengthen it.
- R10: Register bits 7:1 are plain flags: a write while running and out of reset stores them, they read back unchanged, they are cleared by any reset, and they never affect the clock enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_n_i | input | 1 | Power-on indication, low while power is not yet good (asynchronous) |
| ext_rst_i | input | 1 | External reset request, synchronous, active high |
| wdt_rst_i | input | 1 | Watchdog reset request, synchronous, active high |
| reg_we_i | input | 1 | Power-control register write strobe |
| reg_wdata_i | input | 8 | Write data; bit 0 is the idle request |
| reg_rdata_o | output | 8 | Read data; bit 0 is the idle bit, bits 7:1 the flags |
| irq_req_i | input | NUM_IRQ | Interrupt request lines |
| irq_en_i | input | NUM_IRQ | Per-line interrupt enables |
| irq_gen_i | input | 1 | Global interrupt enable |
| cpu_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Timer, serial and I/O clock enable |
| int_rst_o | output | 1 | Internal reset to the core, active high |
| idle_o | output | 1 | Current idle bit |

## Verification
A wrong idle bit shows at once on the core clock enable and on read data bit 0, in the clock after the write or wake event that should have changed it. A wrong reset counter shows as an internal reset pulse that ends one or more clocks early or late, 24 clocks after the request, or as a startup wait of the wrong length after power-on. The bench compares every output against a countdown model on every clock, so any such slip is reported in the cycle it first appears.

// File: rtl/idle_pkg.sv
package idle_pkg;

    localparam int PCON_W   = 8;
    localparam int IDLE_BIT = 0;

    typedef enum logic [1:0] {
        PH_STARTUP = 2'd0,
        PH_RESET   = 2'd1,
        PH_RUN     = 2'd2
    } phase_e;

    typedef struct packed {
        logic [PCON_W-2:0] flags;
        logic              idle;
    } pcon_t;

endpackage

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
    parameter int NUM_IRQ = 4
) (
    input  logic [NUM_IRQ-1:0] irq_req_i,
    input  logic [NUM_IRQ-1:0] irq_en_i,
    input  logic               irq_gen_i,
    output logic               wake_o
);

    logic [NUM_IRQ-1:0] qual;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_qual
        assign qual[i] = irq_req_i[i] & irq_en_i[i];
    end

    assign wake_o = irq_gen_i & (|qual);

endmodule

// File: rtl/idle_rst_seq.sv
module idle_rst_seq
    import idle_pkg::*;
#(
    parameter int STARTUP_CLKS = 64,
    parameter int MC_CLKS      = 12,
    parameter int RST_MCYC     = 2
) (
    input  logic   clk_i,
    input  logic   por_n_i,
    input  logic   rst_req_i,
    output phase_e phase_o
);

    localparam int RST_CLKS = MC_CLKS * RST_MCYC;
    localparam int MAX_CLKS = (STARTUP_CLKS > RST_CLKS) ? STARTUP_CLKS : RST_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);
    localparam logic [CNT_W-1:0] SU_LAST  = CNT_W'(STARTUP_CLKS - 1);
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CLKS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_STARTUP: begin
                if (s_q.cnt == SU_LAST) begin
                    s_d.phase = PH_RESET;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_RESET: begin
                if (rst_req_i) begin
                    s_d.cnt = '0;
                end else if (s_q.cnt == RST_LAST) begin
                    s_d.phase = PH_RUN;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                if (rst_req_i) begin
                    s_d.phase = PH_RESET;
                    s_d.cnt   = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            s_q.phase <= PH_STARTUP;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;

    AST_STARTUP_IGNORES_RST: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (s_q.phase == PH_STARTUP && rst_req_i && s_q.cnt != SU_LAST) |=> (phase_o == PH_STARTUP)); // R9

    AST_RUN_RST_ENTRY: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (phase_o == PH_RUN && rst_req_i) |=> (phase_o == PH_RESET)); // R5

endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
    import idle_pkg::*;
#(
    parameter int NUM_IRQ      = 4,
    parameter int STARTUP_CLKS = 64,
    parameter int MC_CLKS      = 12,
    parameter int RST_MCYC     = 2
) (
    input  logic               clk_i,
    input  logic               por_n_i,
    input  logic               ext_rst_i,
    input  logic               wdt_rst_i,
    input  logic               reg_we_i,
    input  logic [7:0]         reg_wdata_i,
    output logic [7:0]         reg_rdata_o,
    input  logic [NUM_IRQ-1:0] irq_req_i,
    input  logic [NUM_IRQ-1:0] irq_en_i,
    input  logic               irq_gen_i,
    output logic               cpu_clk_en_o,
    output logic               per_clk_en_o,
    output logic               int_rst_o,
    output logic               idle_o
);

    logic   wake;
    logic   rst_req;
    logic   rst_hit;
    phase_e phase;
    pcon_t  pcon_d, pcon_q;

    assign rst_req = ext_rst_i | wdt_rst_i;

    idle_wake_detect #(
        .NUM_IRQ (NUM_IRQ)
    ) wake_i (
        .irq_req_i (irq_req_i),
        .irq_en_i  (irq_en_i),
        .irq_gen_i (irq_gen_i),
        .wake_o    (wake)
    );

    idle_rst_seq #(
        .STARTUP_CLKS (STARTUP_CLKS),
        .MC_CLKS      (MC_CLKS),
        .RST_MCYC     (RST_MCYC)
    ) seq_i (
        .clk_i     (clk_i),
        .por_n_i   (por_n_i),
        .rst_req_i (rst_req),
        .phase_o   (phase)
    );

    assign rst_hit = rst_req && (phase != PH_STARTUP);

    always_comb begin
        pcon_d = pcon_q;
        if (rst_hit || phase != PH_RUN) begin
            pcon_d = '0;
        end else if (pcon_q.idle) begin
            if (wake) begin
                pcon_d.idle = 1'b0;
            end
        end else if (reg_we_i) begin
            pcon_d = pcon_t'(reg_wdata_i);
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            pcon_q <= '0;
        end else begin
            pcon_q <= pcon_d;
        end
    end

    assign reg_rdata_o  = pcon_q;
    assign idle_o       = pcon_q.idle;
    assign per_clk_en_o = (phase != PH_STARTUP);
    assign cpu_clk_en_o = (phase != PH_STARTUP) && !pcon_q.idle;
    assign int_rst_o    = (phase != PH_RUN);

    AST_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (!int_rst_o && !idle_o && !rst_req && reg_we_i && reg_wdata_i[IDLE_BIT]) |=> idle_o); // R1

    AST_IDLE_ENABLES: assert property (@(posedge clk_i) disable iff (!por_n_i)
        idle_o |-> (!cpu_clk_en_o && per_clk_en_o)); // R2

    AST_WAKE_RESUME: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (idle_o && wake && !rst_req) |=> (!idle_o && cpu_clk_en_o && !int_rst_o)); // R3

    AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (idle_o && !wake && !rst_req) |=> idle_o); // R4

    AST_RST_ENDS_IDLE: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (idle_o && rst_req) |=> (int_rst_o && !idle_o)); // R8

endmodule

// File: tb/idle_pwr_ctrl_tb_top.sv
module idle_pwr_ctrl_tb_top;

    localparam int NIRQ = 4;
    localparam int SU   = 64;
    localparam int RSTC = 24;

    logic            clk = 1'b0;
    logic            por_n = 1'b0;
    logic            ext_rst = 1'b0;
    logic            wdt_rst = 1'b0;
    logic            we = 1'b0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic [NIRQ-1:0] irq_req = '0;
    logic [NIRQ-1:0] irq_en = '0;
    logic            irq_gen = 1'b0;
    logic            cpu_en, per_en, irst, idle;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    string tag = "R7";

    int       m_su = SU;
    int       m_rl = RSTC;
    logic [7:0] m_reg = '0;

    always #10 clk = ~clk;

    idle_pwr_ctrl #(
        .NUM_IRQ      (NIRQ),
        .STARTUP_CLKS (SU)
    ) dut_i (
        .clk_i        (clk),
        .por_n_i      (por_n),
        .ext_rst_i    (ext_rst),
        .wdt_rst_i    (wdt_rst),
        .reg_we_i     (we),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq_req_i    (irq_req),
        .irq_en_i     (irq_en),
        .irq_gen_i    (irq_gen),
        .cpu_clk_en_o (cpu_en),
        .per_clk_en_o (per_en),
        .int_rst_o    (irst),
        .idle_o       (idle)
    );

    // Reference model: countdowns for startup and reset, a register byte.
    always @(posedge clk) begin
        bit wake;
        wake = irq_gen && ((irq_req & irq_en) != 0);
        if (!por_n) begin
            m_su = SU; m_rl = RSTC; m_reg = '0;
        end else if (m_su > 0) begin
            m_su = m_su - 1;
        end else if (ext_rst || wdt_rst) begin
            m_rl = RSTC; m_reg = '0;
        end else if (m_rl > 0) begin
            m_rl = m_rl - 1;
        end else if (m_reg[0]) begin
            if (wake) m_reg[0] = 1'b0;
        end else if (we) begin
            m_reg = wdata;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(negedge clk) begin
        logic [11:0] act, exp;
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: act=timeout exp=completion");
            summary();
        end
        if (por_n) begin
            act = {cpu_en, per_en, irst, idle, rdata};
            exp = {(m_su == 0) && !m_reg[0], m_su == 0, (m_su > 0) || (m_rl > 0), m_reg[0], m_reg};
            checks++;
            if (act !== exp) begin
                errors++;
                $display("FAIL %s cyc=%0d {cpu,per,rst,idle,rdata} act=%b exp=%b", tag, cycles, act, exp);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(logic [7:0] v);
        we = 1'b1; wdata = v; step(1);
        we = 1'b0; wdata = '0;
    endtask

    initial begin
        step(3);
        por_n = 1'b1;
        tag = "R7"; step(20);
        tag = "R9"; ext_rst = 1'b1; step(2); ext_rst = 1'b0;
        wdt_rst = 1'b1; step(1); wdt_rst = 1'b0;
        tag = "R7"; step(SU + RSTC);
        step(3);

        tag = "R1"; wr(8'hFE); step(3);     // bit 0 clear: stays running, flags stored
        tag = "R10"; wr(8'h00); step(2);
        tag = "R1"; wr(8'hA5); step(4);     // enter idle with flags
        tag = "R2"; step(4);
        tag = "R10"; wr(8'h00); step(2);    // write while idle ignored
        tag = "R4"; irq_req = 4'b0110; irq_en = 4'b1001; irq_gen = 1'b1; step(4);
        irq_en = 4'b0100; irq_gen = 1'b0; step(4);
        tag = "R3"; irq_gen = 1'b1; step(3);
        irq_req = '0; irq_en = '0; irq_gen = 1'b0; step(2);

        tag = "R5"; wr(8'h01); step(3);
        ext_rst = 1'b1; step(1); ext_rst = 1'b0;
        step(RSTC + 4);
        ext_rst = 1'b1; step(3); ext_rst = 1'b0;   // held request from running
        step(RSTC + 4);

        tag = "R6"; wr(8'h81); step(3);
        wdt_rst = 1'b1; step(1); wdt_rst = 1'b0;
        step(RSTC + 4);

        tag = "R8"; wr(8'h01); step(3);
        irq_req = 4'b0001; irq_en = 4'b0001; irq_gen = 1'b1; ext_rst = 1'b1; step(1);
        ext_rst = 1'b0; step(RSTC + 4);
        irq_req = '0; irq_en = '0; irq_gen = 1'b0;

        tag = "R3"; wr(8'h01); step(2);
        irq_req = 4'b1000; irq_en = 4'b1000; irq_gen = 1'b1; step(1);
        irq_req = '0; step(3);

        tag = "R7"; por_n = 1'b0; step(3); por_n = 1'b1;
        step(SU + RSTC + 4);
        summary();
    end

endmodule